// File: doc/BRIEF.md
# Mailbox Command Issue Engine

This block is a small bus master that delivers one command at a time to a mailbox target built from two 32-bit registers. An upstream controller offers an 8-bit opcode and a 32-bit payload over a valid/ready handshake.

Each attempt works in a fixed order:

- The engine first stores the payload in the target's data register.
- It then writes the command register with the opcode and a run flag in bit 31.
- It reads the command register back until the run flag clears, waiting a fixed number of cycles between reads.
- It judges the status code in the low half of the final read.

An attempt fails when the flag stays set for the whole poll budget or when the status code is not the success code. A failed attempt is repeated from the payload write, up to a fixed number of attempts. After that the engine completes with an error.

The result is a one-cycle completion pulse carrying an error flag. An all-zero opcode is treated as a null command: it completes at once and makes no bus access. The wait between polls is a cycle count derived from the clock frequency and a microsecond interval. The count itself is a parameter, so a bench can shorten it.

Top module: `mbox_issue_engine`

## Requirements
- R1: After reset `reqReady` is 1, `busReq` is 0 and `doneValid` is 0.
- R2: Each attempt performs two writes before any read, in this order:
  - the payload to the data register at address 0x6C04;
  - then the command register at address 0x6C00, with `busWdata` bit 31 = 1, bits 7:0 = opcode and all other bits 0.
- R3: The first read of the command register (address 0x6C00) starts in the cycle after the command write is acknowledged. After a read that returns bit 31 = 1, and that is not the last of the poll budget, the bus stays idle for exactly `GAP_CYCLES` cycles before the next read.
- R4: Polling ends on the first read with bit 31 = 0. If bits 15:0 of that read equal 0x0040 (other bits ignored), `doneValid` is 1 with `doneErr` = 0 in the next cycle.
- R5: A read with bit 31 = 0 and bits 15:0 not equal to 0x0040 fails the attempt. If attempts remain, the next attempt's payload write is requested in the next cycle.
- R6: When `POLL_LIMIT` (100) consecutive reads of one attempt all return bit 31 = 1, the attempt fails. If attempts remain, a new attempt starts with the payload write in the next cycle.
- R7: When `ATTEMPT_LIMIT` (10) attempts have failed, `doneValid` is 1 with `doneErr` = 1 in the cycle after the last read, and no further bus access is made.
- R8: A request with opcode 0x00 gives `doneValid` = 1 with `doneErr` = 0 in the cycle after acceptance, with no bus access.
- R9: `reqReady` is 0 from the cycle after acceptance through the `doneValid` cycle. `doneValid` lasts exactly one cycle.
- R10: Only one access is outstanding at a time. While `busReq` is 1 and `busAck` is 0, `busReq`, `busWrite`, `busAddr` and `busWdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request offered |
| reqReady | output | 1 | Engine idle, request accepted when both high |
| reqOpcode | input | 8 | Command opcode, 0x00 = null command |
| reqPayload | input | 32 | Payload for the data register |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Completion failed after all attempts |
| busReq | output | 1 | Bus access request, held until acknowledged |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 16 | Register address |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Access acknowledge, read data valid in this cycle |
| busRdata | input | 32 | Read data |

## Verification
Two decisions can land on the same poll acknowledge:

- whether the read ends the attempt;
- whether that failed attempt is also the last one allowed.

A run in which every read returns a bad status code makes the tenth failure coincide with the final status judgement. A run in which the target never clears the run flag makes the hundredth busy read of the tenth attempt end both the poll budget and the attempt budget at once.

The bench model predicts the full address, data and idle-gap sequence of the bus, plus the completion cycle and flag. It compares these against the bus port at every acknowledge and against `reqReady` on every clock. A missed or extra retry therefore shows up either as an access the model does not expect or as a wrong error flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // bus access selected by the control for the current cycle
  typedef enum logic [1:0] {
    BUS_NONE     = 2'd0,
    BUS_WR_DATA  = 2'd1,
    BUS_WR_IFACE = 2'd2,
    BUS_RD_IFACE = 2'd3
  } busOp_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_DATA  = 3'd1,
    ST_WR_IFACE = 3'd2,
    ST_POLL     = 3'd3,
    ST_GAP      = 3'd4,
    ST_DONE     = 3'd5
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   latchReq;
    logic   clrErr;
    logic   setErr;
    logic   clrAttempt;
    logic   incAttempt;
    logic   clrPoll;
    logic   incPoll;
    logic   clrGap;
    logic   incGap;
    busOp_e busOp;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic opZero;
    logic rdBusy;
    logic rdOk;
    logic pollLast;
    logic attemptLast;
    logic gapLast;
  } dpStatus_t;

endpackage

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int OP_W          = 8,
  parameter int ADDR_W        = 16,
  parameter int CODE_W        = 16,
  parameter logic [ADDR_W-1:0] IFACE_ADDR = 16'h6C00,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h6C04,
  parameter logic [CODE_W-1:0] OK_CODE    = 16'h0040,
  parameter int POLL_LIMIT    = 100,
  parameter int ATTEMPT_LIMIT = 10,
  parameter int GAP_CYCLES    = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [OP_W-1:0]   reqOpcode,
  input  logic [DATA_W-1:0] reqPayload,
  input  logic [DATA_W-1:0] busRdata,
  output dpStatus_t         st,
  output logic              doneErr,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int AW = $clog2(ATTEMPT_LIMIT + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int RUN_BIT = DATA_W - 1;
  localparam logic [PW-1:0] POLL_TOP = PW'(POLL_LIMIT - 1);
  localparam logic [AW-1:0] ATT_TOP  = AW'(ATTEMPT_LIMIT - 1);
  localparam logic [GW-1:0] GAP_TOP  = GW'(GAP_CYCLES - 1);

  logic [DATA_W-1:0] payloadReg;
  logic [OP_W-1:0]   opReg;
  logic [PW-1:0]     pollCnt;
  logic [AW-1:0]     attemptCnt;
  logic [GW-1:0]     gapCnt;
  logic              errReg;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      payloadReg <= '0;
      opReg      <= '0;
    end else if (stb.latchReq) begin
      payloadReg <= reqPayload;
      opReg      <= reqOpcode;
    end
  end

  // poll counter: reads done in the current attempt
  always_ff @(posedge clk) begin
    if (!rstN)              pollCnt <= '0;
    else if (stb.clrPoll)   pollCnt <= '0;
    else if (stb.incPoll)   pollCnt <= pollCnt + 1'b1;
  end

  // attempt counter: failed attempts so far
  always_ff @(posedge clk) begin
    if (!rstN)                attemptCnt <= '0;
    else if (stb.clrAttempt)  attemptCnt <= '0;
    else if (stb.incAttempt)  attemptCnt <= attemptCnt + 1'b1;
  end

  // inter-poll spacing counter
  always_ff @(posedge clk) begin
    if (!rstN)             gapCnt <= '0;
    else if (stb.clrGap)   gapCnt <= '0;
    else if (stb.incGap)   gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             errReg <= 1'b0;
    else if (stb.clrErr)   errReg <= 1'b0;
    else if (stb.setErr)   errReg <= 1'b1;
  end

  assign doneErr = errReg;

  // status towards the control
  always_comb begin
    st.opZero      = (reqOpcode == '0);
    st.rdBusy      = busRdata[RUN_BIT];
    st.rdOk        = (busRdata[CODE_W-1:0] == OK_CODE);
    st.pollLast    = (pollCnt == POLL_TOP);
    st.attemptLast = (attemptCnt == ATT_TOP);
    st.gapLast     = (gapCnt == GAP_TOP);
  end

  logic unusedRdBits;
  assign unusedRdBits = ^busRdata[RUN_BIT-1:CODE_W];

  // bus port mux
  always_comb begin
    busReq   = (stb.busOp != BUS_NONE);
    busWrite = 1'b0;
    busAddr  = '0;
    busWdata = '0;
    unique case (stb.busOp)
      BUS_WR_DATA: begin
        busWrite = 1'b1;
        busAddr  = DATA_ADDR;
        busWdata = payloadReg;
      end
      BUS_WR_IFACE: begin
        busWrite = 1'b1;
        busAddr  = IFACE_ADDR;
        busWdata = {1'b1, {(DATA_W-1-OP_W){1'b0}}, opReg};
      end
      BUS_RD_IFACE: begin
        busAddr  = IFACE_ADDR;
      end
      default: ;
    endcase
  end

  // R6: never more reads in an attempt than the budget allows
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PW'(POLL_LIMIT));

  // R7: attempt count stays inside the retry budget
  a_r7_attempt_bound: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt < AW'(ATTEMPT_LIMIT));

  // R2: every command-register write carries the run flag
  a_r2_run_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == IFACE_ADDR) |-> busWdata[RUN_BIT]);

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busAck,
  input  dpStatus_t  st,
  output logic       reqReady,
  output logic       doneValid,
  output ctlStrobe_t stb
);

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.busOp = BUS_NONE;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq   = 1'b1;
          stb.clrErr     = 1'b1;
          stb.clrAttempt = 1'b1;
          stateNext      = st.opZero ? ST_DONE : ST_WR_DATA;
        end
      end
      ST_WR_DATA: begin
        stb.busOp = BUS_WR_DATA;
        if (busAck) stateNext = ST_WR_IFACE;
      end
      ST_WR_IFACE: begin
        stb.busOp = BUS_WR_IFACE;
        if (busAck) begin
          stb.clrPoll = 1'b1;
          stateNext   = ST_POLL;
        end
      end
      ST_POLL: begin
        stb.busOp = BUS_RD_IFACE;
        if (busAck) begin
          stb.incPoll = 1'b1;
          if (!st.rdBusy && st.rdOk) begin
            stateNext = ST_DONE;
          end else if (!st.rdBusy || st.pollLast) begin
            // attempt failed
            if (st.attemptLast) begin
              stb.setErr = 1'b1;
              stateNext  = ST_DONE;
            end else begin
              stb.incAttempt = 1'b1;
              stateNext      = ST_WR_DATA;
            end
          end else begin
            stb.clrGap = 1'b1;
            stateNext  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        stb.incGap = 1'b1;
        if (st.gapLast) stateNext = ST_POLL;
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9: no new request accepted while completing
  a_r9_ready_low_done: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);

  // R8: an idle engine drives no bus access
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (stb.busOp == BUS_NONE));

endmodule

// File: rtl/mbox_issue_engine.sv
module mbox_issue_engine
  import mbx_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int OP_W          = 8,
  parameter int ADDR_W        = 16,
  parameter int POLL_LIMIT    = 100,
  parameter int ATTEMPT_LIMIT = 10,
  parameter int CLK_HZ        = 200_000_000,
  parameter int GAP_US        = 10,
  parameter int GAP_CYCLES    = (CLK_HZ / 1_000_000) * GAP_US
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [OP_W-1:0]   reqOpcode,
  input  logic [DATA_W-1:0] reqPayload,
  output logic              doneValid,
  output logic              doneErr,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  ctlStrobe_t stb;
  dpStatus_t  st;

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busAck    (busAck),
    .st        (st),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .stb       (stb)
  );

  mbx_dpath #(
    .DATA_W        (DATA_W),
    .OP_W          (OP_W),
    .ADDR_W        (ADDR_W),
    .POLL_LIMIT    (POLL_LIMIT),
    .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
    .GAP_CYCLES    (GAP_CYCLES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqOpcode  (reqOpcode),
    .reqPayload (reqPayload),
    .busRdata   (busRdata),
    .st         (st),
    .doneErr    (doneErr),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata)
  );

  // R10: a pending access holds still until acknowledged
  a_r10_hold_access: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite)
                             && $stable(busWdata)));

endmodule

// File: tb/mbox_issue_engine_tb_top.sv
`timescale 1ns/1ps
module mbox_issue_engine_tb_top;

  localparam int GAP   = 3;
  localparam int POLLS = 100;
  localparam int TRIES = 10;
  localparam logic [31:0] BUSYW = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqOpcode = '0;
  logic [31:0] reqPayload = '0;
  logic        doneValid, doneErr;
  logic        busReq, busWrite;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  always #2.5 clk = ~clk;

  mbox_issue_engine #(.GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOpcode(reqOpcode), .reqPayload(reqPayload),
    .doneValid(doneValid), .doneErr(doneErr),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [31:0] wdata;
    int          idle;
    string       tag;
  } txn_t;

  int compared = 0, mismatched = 0;
  txn_t expQ[$];
  logic [31:0] respQ[$];
  bit   expErr, busyM, lastOpZero, finished;
  int   idleCnt = 0, doneCount = 0, ackLat = 0, latCnt = 0;
  bit   prevPend;
  logic [15:0] prevAddr;
  logic [31:0] prevWdata;
  bit   prevWr;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural prediction of the whole command from the scripted replies
  task automatic buildExpect(logic [7:0] op, logic [31:0] pay);
    int idx = 0;
    bit timedOut = 0;
    expQ.delete();
    lastOpZero = (op == 8'h00);
    if (op == 8'h00) begin expErr = 0; return; end
    for (int a = 0; a < TRIES; a++) begin
      txn_t t;
      t.wr = 1; t.addr = 16'h6C04; t.wdata = pay; t.idle = 0;
      t.tag = (a == 0) ? "R2" : (timedOut ? "R6" : "R5");
      expQ.push_back(t);
      t.wr = 1; t.addr = 16'h6C00; t.wdata = 32'h8000_0000 | {24'h0, op}; t.idle = 0; t.tag = "R2";
      expQ.push_back(t);
      timedOut = 1;
      for (int p = 0; p < POLLS; p++) begin
        logic [31:0] r;
        r = (idx < respQ.size()) ? respQ[idx] : BUSYW;
        idx++;
        t.wr = 0; t.addr = 16'h6C00; t.wdata = 32'h0; t.idle = (p == 0) ? 0 : GAP; t.tag = "R3";
        expQ.push_back(t);
        if (!r[31]) begin
          timedOut = 0;
          if (r[15:0] == 16'h0040) begin expErr = 0; return; end
          break;
        end
      end
    end
    expErr = 1;
  endtask

  // target model
  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; latCnt <= 0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busReq) begin
      if (latCnt >= ackLat) begin
        busAck <= 1'b1;
        latCnt <= 0;
        if (!busWrite) busRdata <= (respQ.size() > 0) ? respQ.pop_front() : BUSYW;
        else           busRdata <= 32'h0;
      end else latCnt <= latCnt + 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(reqReady == !busyM, "R9", "reqReady", reqReady, !busyM);
      if (prevPend)
        check(busReq && busAddr == prevAddr && busWdata == prevWdata && busWrite == prevWr,
              "R10", "held access", {busReq, busAddr}, {1'b1, prevAddr});
      prevPend = busReq && !busAck;
      prevAddr = busAddr; prevWdata = busWdata; prevWr = busWrite;
      if (busReq && busAck) begin
        if (expQ.size() == 0) begin
          check(0, lastOpZero ? "R8" : "R7", "unexpected access addr", busAddr, 0);
        end else begin
          txn_t e;
          e = expQ.pop_front();
          check(busWrite == e.wr && busAddr == e.addr, e.tag, "access kind/addr",
                {busWrite, busAddr}, {e.wr, e.addr});
          if (e.wr) check(busWdata == e.wdata, e.tag, "write data", busWdata, e.wdata);
          check(idleCnt == e.idle, e.tag, "idle cycles before access", idleCnt, e.idle);
        end
        idleCnt = 0;
      end else if (doneValid) begin
        check(busyM, "R9", "done without request", 0, 1);
        check(expQ.size() == 0, expErr ? "R7" : "R4", "accesses left at done", expQ.size(), 0);
        check(doneErr == expErr, lastOpZero ? "R8" : (expErr ? "R7" : "R4"),
              "doneErr", doneErr, expErr);
        check(idleCnt == 0, lastOpZero ? "R8" : "R4", "done latency", idleCnt, 0);
        busyM = 0; idleCnt = 0; doneCount++;
      end else if (reqValid && reqReady) begin
        buildExpect(reqOpcode, reqPayload);
        busyM = 1; idleCnt = 0;
      end else if (!busReq) begin
        idleCnt++;
      end
    end
  end

  task automatic runCmd(logic [7:0] op, logic [31:0] pay, int lat);
    int n = doneCount;
    ackLat = lat;
    @(posedge clk); #1;
    reqOpcode = op; reqPayload = pay; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    while (doneCount == n) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(busReq == 1'b0, "R1", "busReq after reset", busReq, 0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);

    // R4: success on first read
    respQ = '{32'h0000_0040};
    runCmd(8'h13, 32'hDEAD_BEEF, 0);
    // R3/R4: two busy reads, then success
    respQ = '{BUSYW, BUSYW, 32'h0000_0040};
    runCmd(8'h14, 32'h1234_5678, 1);
    // R5: illegal code then success
    respQ = '{32'h0000_0090, 32'h0000_0040};
    runCmd(8'h07, 32'h0000_0001, 2);
    // R5/R4: thread-unavailable, busy-code, then success with upper bits set
    respQ = '{32'h0000_0082, BUSYW, 32'h0000_0080, 32'h1234_0040};
    runCmd(8'h16, 32'hA5A5_5A5A, 0);
    // R8: null opcode
    respQ = '{32'h0000_0040};
    runCmd(8'h00, 32'hFFFF_FFFF, 0);
    respQ.delete();
    // R7: every attempt returns a failing code
    for (int i = 0; i < TRIES; i++) respQ.push_back(32'h0000_0090);
    runCmd(8'h08, 32'h0BAD_F00D, 0);
    // R6: first attempt times out, second gets a wrong code, third succeeds
    respQ.delete();
    for (int i = 0; i < POLLS; i++) respQ.push_back(BUSYW);
    respQ.push_back(32'h0000_0140);
    respQ.push_back(32'h0000_0040);
    runCmd(8'h15, 32'h5555_AAAA, 1);
    // R6/R7: target never clears the run flag
    respQ.delete();
    runCmd(8'h02, 32'h0000_0004, 0);
    // back-to-back full-width opcode
    respQ = '{32'h0000_0040};
    runCmd(8'hFF, 32'hFFFF_FFFF, 2);
    repeat (4) @(posedge clk);
    finish();
  end

endmodule